// File: doc/BRIEF.md
# Controller Queue-Port Messaging Unit

This block is the device-side messaging unit of a storage controller. A host reaches it through a 32-bit register window. Three FIFOs sit behind that window. The free list holds offsets of request packets kept in controller memory. The post FIFO carries request words that the host submits. The completion FIFO carries finished requests back to the host. Two port addresses have side effects on access. A read pops a FIFO and a write pushes one, so the host can take a free packet, post a request, collect a completion and hand a packet back, each with one register access.

The controller processor is not part of this block. A small interface stands in for it. That interface pops posted words, injects completions (the posted word, or the low 32 bits of a context value when the request asks for that), reads the inbound message registers and the doorbell, and writes the outbound message registers. The controller finishes a non-queued command by writing the inbound message value back into the matching outbound message register. Each direction has a status register and a mask register, and each direction drives one interrupt line built from them.

Top module: `qpmu_top`

## Requirements
- R1: After reset the post and completion FIFOs are empty. The free list holds FREE_COUNT entries, FREE_BASE + i*PKT_BYTES for i = 0 upward, in that order. Message registers, doorbell and masks are zero, and both interrupt lines are low.
- R2: A host read of 0x40 pops the oldest free-list entry. The value appears on host_rdata after the clock edge that takes the read. If the free list is empty, the read returns 0xFFFFFFFF and pops nothing.
- R3: A host write to 0x40 appends the written word, unchanged, to the post FIFO. This holds for a controller-memory offset and for the host-memory form, which is bit 31 set OR'ed with the 32-byte-aligned bus address shifted right by 5. The oldest entry is shown on ctl_post_word while ctl_post_valid is high, and it stays there until ctl_post_take removes it. A take on an empty FIFO is ignored.
- R4: ctl_cpl_push appends ctl_cpl_word to the completion FIFO. When ctl_cpl_use_ctx is high, it appends ctl_cpl_ctx instead.
- R5: A host read of 0x44 pops the oldest completion. If the completion FIFO is empty, the read returns 0xFFFFFFFF and pops nothing.
- R6: A host write to 0x44 with bit 31 clear appends the word to the free list. A write with bit 31 set is ignored.
- R7: A push into a full FIFO is dropped, and it sets outbound status bit 4. The host clears that bit by writing 1 to it at 0x30.
- R8: A host write to 0x10 or 0x14 stores inbound message 0 or 1, shows it on ctl_imsg0 or ctl_imsg1, and sets inbound status bit 0 or 1. Bit k of ctl_imsg_ack clears inbound status bit k.
- R9: ctl_omsg_wr bit k writes ctl_omsg_data into outbound message k, which the host reads at 0x18 (k=0) or 0x1C (k=1). The write also sets outbound status bit k, and the host clears that bit by writing 1 to it at 0x30.
- R10: Outbound status bit 3 is high exactly while the completion FIFO holds an entry. Writes to 0x30 do not clear it.
- R11: host_irq is high when some outbound status bit (read at 0x30) is set while the same bit of the outbound mask at 0x34 is 0. The mask is read/write.
- R12: A host write to 0x20 ORs the word into the doorbell, and ctl_db_clr clears doorbell bits. Inbound status (0x24) bit 2 is high while the doorbell is nonzero, and bit 3 is high while the post FIFO holds an entry. ctl_irq is high when an inbound status bit is set whose bit in the inbound mask at 0x28 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 8 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, registered, valid after the read edge |
| host_irq | output | 1 | Outbound interrupt to the host |
| ctl_post_valid | output | 1 | Post FIFO holds an entry |
| ctl_post_word | output | 32 | Oldest posted request word |
| ctl_post_take | input | 1 | Controller removes the oldest posted word |
| ctl_cpl_push | input | 1 | Controller injects a completion |
| ctl_cpl_word | input | 32 | Posted word of the completed request |
| ctl_cpl_use_ctx | input | 1 | Queue the context value instead of the word |
| ctl_cpl_ctx | input | 32 | Low 32 bits of the request context |
| ctl_imsg0 | output | 32 | Inbound message 0 |
| ctl_imsg1 | output | 32 | Inbound message 1 |
| ctl_imsg_ack | input | 2 | Clears inbound message status bits |
| ctl_omsg_wr | input | 2 | Writes outbound message 0 / 1 |
| ctl_omsg_data | input | 32 | Outbound message value |
| ctl_doorbell | output | 32 | Current doorbell bits |
| ctl_db_clr | input | 32 | Doorbell bits to clear |
| ctl_irq | output | 1 | Inbound interrupt to the controller |

## Verification
The bench builds the block with a queue depth of 4, three initial free packets, a base offset of 0x2000 and a packet stride of 0x40. With a depth this small, a handful of host accesses fills each FIFO, so the dropped-push path and the overflow flag come up often during the random phase. Three initial packets also let the free list drain to empty, so the 0xFFFFFFFF reply and its refill through the outbound port get checked early. The small stride keeps the reset contents easy to predict in the bench.

// File: rtl/mu_pkg.sv
// Package: register offsets and status bit positions shared by the
// messaging unit and its checker. Offsets are what host software decodes,
// so they are fixed; the rest is local numbering.
package mu_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_IMSG0 = 8'h10;
    localparam logic [ADDR_W-1:0] A_IMSG1 = 8'h14;
    localparam logic [ADDR_W-1:0] A_OMSG0 = 8'h18;
    localparam logic [ADDR_W-1:0] A_OMSG1 = 8'h1C;
    localparam logic [ADDR_W-1:0] A_DBELL = 8'h20;
    localparam logic [ADDR_W-1:0] A_ISTAT = 8'h24;
    localparam logic [ADDR_W-1:0] A_IMASK = 8'h28;
    localparam logic [ADDR_W-1:0] A_OSTAT = 8'h30;
    localparam logic [ADDR_W-1:0] A_OMASK = 8'h34;
    localparam logic [ADDR_W-1:0] A_INQ   = 8'h40;
    localparam logic [ADDR_W-1:0] A_OUTQ  = 8'h44;

    localparam logic [DATA_W-1:0] EMPTY_WORD = 32'hFFFF_FFFF;
    localparam int HOST_TAG_BIT = 31;

    // inbound status bit numbers
    localparam int IS_MSG0 = 0;
    localparam int IS_MSG1 = 1;
    localparam int IS_DB   = 2;
    localparam int IS_PNE  = 3;
    localparam int ISTAT_W = 4;

    // outbound status bit numbers
    localparam int OS_MSG0 = 0;
    localparam int OS_MSG1 = 1;
    localparam int OS_QNE  = 3;
    localparam int OS_OVF  = 4;
    localparam int OSTAT_W = 5;
endpackage

// File: rtl/mu_fifo.sv
// Single-clock FIFO with one pusher and one popper.
// Assumes DEPTH >= 2 and INIT_COUNT <= DEPTH. On reset it may be preloaded
// with INIT_COUNT words INIT_BASE + i*INIT_STEP (oldest first).
// A push while full is refused (the caller flags the drop); a pop while
// empty is ignored. Push and pop in the same cycle are both honoured.
module mu_fifo #(
    parameter int          W          = 32,
    parameter int          DEPTH      = 8,
    parameter int          INIT_COUNT = 0,
    parameter logic [31:0] INIT_BASE  = 32'h0,
    parameter logic [31:0] INIT_STEP  = 32'h0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage: preload on reset, write accepted pushes afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i < INIT_COUNT) ? W'(INIT_BASE + INIT_STEP * i) : '0;
            end
        end else if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= PTR_W'(INIT_COUNT % DEPTH);
            count  <= CNT_W'(INIT_COUNT);
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mu_irq_unit.sv
// Status/mask/interrupt cell for one direction.
// Bits selected by LEVEL_MASK follow level_in directly; the others are
// sticky: set by set_evt, cleared by clr_evt, with set winning a tie.
// irq is high when any status bit is set whose mask bit is 0.
module mu_irq_unit #(
    parameter int           W          = 4,
    parameter logic [W-1:0] LEVEL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_evt,
    input  logic [W-1:0] clr_evt,
    input  logic [W-1:0] level_in,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         irq
);
    // One status bit per position: a wire for level bits, a flop otherwise.
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (LEVEL_MASK[b]) begin : g_level
            assign status[b] = level_in[b];
        end else begin : g_sticky
            logic held;
            // Sticky event bit, set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)          held <= 1'b0;
                else if (set_evt[b]) held <= 1'b1;
                else if (clr_evt[b]) held <= 1'b0;
            end
            assign status[b] = held;
        end
    end

    // Mask register, written whole by the owning side.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    assign irq = |(status & ~mask);
endmodule

// File: rtl/qpmu_top.sv
// Queue-port messaging unit, device side.
// Host side: one read or one write per cycle (never both), registered read
// data valid after the read edge. Offsets 0x40 and 0x44 pop on read and push
// on write. Controller side: post FIFO drain, completion injection,
// messages and doorbell. All FIFOs have one pusher and one popper.
module qpmu_top
    import mu_pkg::*;
#(
    parameter int          Q_DEPTH    = 8,
    parameter int          FREE_COUNT = 6,
    parameter logic [31:0] FREE_BASE  = 32'h0000_1000,
    parameter logic [31:0] PKT_BYTES  = 32'h0000_0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_irq,
    output logic        ctl_post_valid,
    output logic [31:0] ctl_post_word,
    input  logic        ctl_post_take,
    input  logic        ctl_cpl_push,
    input  logic [31:0] ctl_cpl_word,
    input  logic        ctl_cpl_use_ctx,
    input  logic [31:0] ctl_cpl_ctx,
    output logic [31:0] ctl_imsg0,
    output logic [31:0] ctl_imsg1,
    input  logic [1:0]  ctl_imsg_ack,
    input  logic [1:0]  ctl_omsg_wr,
    input  logic [31:0] ctl_omsg_data,
    output logic [31:0] ctl_doorbell,
    input  logic [31:0] ctl_db_clr,
    output logic        ctl_irq
);
    // ---------------- host access decode ----------------
    logic wr_imsg0, wr_imsg1, wr_dbell, wr_imask, wr_ostat, wr_omask;
    logic wr_inq, wr_outq, rd_inq, rd_outq;

    assign wr_imsg0 = host_wr && (host_addr == A_IMSG0);
    assign wr_imsg1 = host_wr && (host_addr == A_IMSG1);
    assign wr_dbell = host_wr && (host_addr == A_DBELL);
    assign wr_imask = host_wr && (host_addr == A_IMASK);
    assign wr_ostat = host_wr && (host_addr == A_OSTAT);
    assign wr_omask = host_wr && (host_addr == A_OMASK);
    assign wr_inq   = host_wr && (host_addr == A_INQ);
    assign wr_outq  = host_wr && (host_addr == A_OUTQ);
    assign rd_inq   = host_rd && (host_addr == A_INQ);
    assign rd_outq  = host_rd && (host_addr == A_OUTQ);

    // ---------------- FIFOs ----------------
    logic [31:0] free_head, post_head, cpl_head, cpl_data;
    logic        free_empty, free_full, post_empty, post_full;
    logic        cpl_empty, cpl_full, free_push;

    // Only controller-memory offsets (tag bit clear) go back on the free list.
    assign free_push = wr_outq && !host_wdata[HOST_TAG_BIT];
    assign cpl_data  = ctl_cpl_use_ctx ? ctl_cpl_ctx : ctl_cpl_word;

    mu_fifo #(
        .W(32), .DEPTH(Q_DEPTH), .INIT_COUNT(FREE_COUNT),
        .INIT_BASE(FREE_BASE), .INIT_STEP(PKT_BYTES)
    ) u_free_q (
        .clk(clk), .rst_n(rst_n),
        .push(free_push), .push_data(host_wdata), .pop(rd_inq),
        .head(free_head), .empty(free_empty), .full(free_full)
    );

    mu_fifo #(
        .W(32), .DEPTH(Q_DEPTH), .INIT_COUNT(0),
        .INIT_BASE(32'h0), .INIT_STEP(32'h0)
    ) u_post_q (
        .clk(clk), .rst_n(rst_n),
        .push(wr_inq), .push_data(host_wdata), .pop(ctl_post_take),
        .head(post_head), .empty(post_empty), .full(post_full)
    );

    mu_fifo #(
        .W(32), .DEPTH(Q_DEPTH), .INIT_COUNT(0),
        .INIT_BASE(32'h0), .INIT_STEP(32'h0)
    ) u_cpl_q (
        .clk(clk), .rst_n(rst_n),
        .push(ctl_cpl_push), .push_data(cpl_data), .pop(rd_outq),
        .head(cpl_head), .empty(cpl_empty), .full(cpl_full)
    );

    assign ctl_post_valid = !post_empty;
    assign ctl_post_word  = post_head;

    logic any_drop;
    assign any_drop = (free_push && free_full) || (wr_inq && post_full) ||
                      (ctl_cpl_push && cpl_full);

    // ---------------- message and doorbell registers ----------------
    logic [31:0] imsg0_q, imsg1_q, omsg0_q, omsg1_q, dbell_q;

    // Inbound messages: written by the host only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imsg0_q <= '0;
            imsg1_q <= '0;
        end else begin
            if (wr_imsg0) imsg0_q <= host_wdata;
            if (wr_imsg1) imsg1_q <= host_wdata;
        end
    end

    // Outbound messages: written by the controller only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            omsg0_q <= '0;
            omsg1_q <= '0;
        end else begin
            if (ctl_omsg_wr[0]) omsg0_q <= ctl_omsg_data;
            if (ctl_omsg_wr[1]) omsg1_q <= ctl_omsg_data;
        end
    end

    // Doorbell: host ORs bits in, controller clears; a new ring wins.
    always_ff @(posedge clk) begin
        if (!rst_n) dbell_q <= '0;
        else        dbell_q <= (dbell_q & ~ctl_db_clr) | (wr_dbell ? host_wdata : 32'h0);
    end

    assign ctl_imsg0    = imsg0_q;
    assign ctl_imsg1    = imsg1_q;
    assign ctl_doorbell = dbell_q;

    // ---------------- interrupt cells ----------------
    logic [ISTAT_W-1:0] istat, imask, iset, iclr, ilvl;
    logic [OSTAT_W-1:0] ostat, omask, oset, oclr, olvl;

    always_comb begin
        iset = '0;
        iset[IS_MSG0] = wr_imsg0;
        iset[IS_MSG1] = wr_imsg1;
        iclr = '0;
        iclr[IS_MSG0] = ctl_imsg_ack[0];
        iclr[IS_MSG1] = ctl_imsg_ack[1];
        ilvl = '0;
        ilvl[IS_DB]  = |dbell_q;
        ilvl[IS_PNE] = !post_empty;
    end

    always_comb begin
        oset = '0;
        oset[OS_MSG0] = ctl_omsg_wr[0];
        oset[OS_MSG1] = ctl_omsg_wr[1];
        oset[OS_OVF]  = any_drop;
        oclr = wr_ostat ? host_wdata[OSTAT_W-1:0] : '0;
        olvl = '0;
        olvl[OS_QNE] = !cpl_empty;
    end

    mu_irq_unit #(
        .W(ISTAT_W), .LEVEL_MASK(ISTAT_W'((1 << IS_DB) | (1 << IS_PNE)))
    ) u_in_irq (
        .clk(clk), .rst_n(rst_n),
        .set_evt(iset), .clr_evt(iclr), .level_in(ilvl),
        .mask_we(wr_imask), .mask_wdata(host_wdata[ISTAT_W-1:0]),
        .status(istat), .mask(imask), .irq(ctl_irq)
    );

    mu_irq_unit #(
        .W(OSTAT_W), .LEVEL_MASK(OSTAT_W'(1 << OS_QNE))
    ) u_out_irq (
        .clk(clk), .rst_n(rst_n),
        .set_evt(oset), .clr_evt(oclr), .level_in(olvl),
        .mask_we(wr_omask), .mask_wdata(host_wdata[OSTAT_W-1:0]),
        .status(ostat), .mask(omask), .irq(host_irq)
    );

    // ---------------- host read path ----------------
    logic [31:0] rd_mux;

    // Select the read value; port reads report EMPTY_WORD when nothing to pop.
    always_comb begin
        unique case (host_addr)
            A_IMSG0: rd_mux = imsg0_q;
            A_IMSG1: rd_mux = imsg1_q;
            A_OMSG0: rd_mux = omsg0_q;
            A_OMSG1: rd_mux = omsg1_q;
            A_DBELL: rd_mux = dbell_q;
            A_ISTAT: rd_mux = 32'(istat);
            A_IMASK: rd_mux = 32'(imask);
            A_OSTAT: rd_mux = 32'(ostat);
            A_OMASK: rd_mux = 32'(omask);
            A_INQ:   rd_mux = free_empty ? EMPTY_WORD : free_head;
            A_OUTQ:  rd_mux = cpl_empty ? EMPTY_WORD : cpl_head;
            default: rd_mux = 32'h0;
        endcase
    end

    // Capture read data on the edge that takes the read.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end
endmodule

// File: rtl/qpmu_checker.sv
// Temporal checks on the messaging unit, bound to every qpmu_top instance.
// Looks only at ports and at the FIFO flags and status the top computes.
module qpmu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_rd,
    input logic [7:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic [31:0] host_rdata,
    input logic        host_irq,
    input logic        ctl_post_valid,
    input logic [31:0] ctl_post_word,
    input logic        ctl_post_take,
    input logic        ctl_cpl_push,
    input logic        free_empty,
    input logic        cpl_empty,
    input logic        cpl_full,
    input logic [4:0]  ostat
);
    // R2
    empty_free_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 8'h40 && free_empty) |=> (host_rdata == 32'hFFFF_FFFF));

    // R5
    empty_cpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 8'h44 && cpl_empty) |=> (host_rdata == 32'hFFFF_FFFF));

    // R3
    post_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_post_valid && !ctl_post_take) |=> (ctl_post_valid && $stable(ctl_post_word)));

    // R7
    overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_cpl_push && cpl_full) |=> ostat[4]);

    // R11
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 8'h34 && host_wdata == 32'hFFFF_FFFF) |=> !host_irq);

    // R6
    tagged_return_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 8'h44 && host_wdata[31] && free_empty) |=> free_empty);
endmodule

bind qpmu_top qpmu_checker u_qpmu_chk (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
    .ctl_post_valid(ctl_post_valid), .ctl_post_word(ctl_post_word),
    .ctl_post_take(ctl_post_take), .ctl_cpl_push(ctl_cpl_push),
    .free_empty(free_empty), .cpl_empty(cpl_empty), .cpl_full(cpl_full),
    .ostat(ostat)
);

// File: tb/qpmu_top_bench.sv
module qpmu_top_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 4;
    localparam int          NFREE      = 3;
    localparam logic [31:0] BASE       = 32'h0000_2000;
    localparam logic [31:0] STEP       = 32'h0000_0040;
    localparam logic [31:0] EMPTY      = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_irq, ctl_post_valid, ctl_irq;
    logic [31:0] ctl_post_word, ctl_imsg0, ctl_imsg1, ctl_doorbell;
    logic        ctl_post_take = 1'b0, ctl_cpl_push = 1'b0, ctl_cpl_use_ctx = 1'b0;
    logic [31:0] ctl_cpl_word = '0, ctl_cpl_ctx = '0, ctl_omsg_data = '0, ctl_db_clr = '0;
    logic [1:0]  ctl_imsg_ack = '0, ctl_omsg_wr = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model of the three queues and the overflow flag
    logic [31:0] fq[$], pq[$], cq[$];
    bit          ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    qpmu_top #(.Q_DEPTH(DEPTH), .FREE_COUNT(NFREE), .FREE_BASE(BASE), .PKT_BYTES(STEP)) u_qpmu_top (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .ctl_post_valid(ctl_post_valid), .ctl_post_word(ctl_post_word),
        .ctl_post_take(ctl_post_take), .ctl_cpl_push(ctl_cpl_push),
        .ctl_cpl_word(ctl_cpl_word), .ctl_cpl_use_ctx(ctl_cpl_use_ctx),
        .ctl_cpl_ctx(ctl_cpl_ctx), .ctl_imsg0(ctl_imsg0), .ctl_imsg1(ctl_imsg1),
        .ctl_imsg_ack(ctl_imsg_ack), .ctl_omsg_wr(ctl_omsg_wr),
        .ctl_omsg_data(ctl_omsg_data), .ctl_doorbell(ctl_doorbell),
        .ctl_db_clr(ctl_db_clr), .ctl_irq(ctl_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // each task starts and ends at a falling edge, one rising edge inside
    task automatic hwr(input logic [7:0] a, input logic [31:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic hrd(input logic [7:0] a, output logic [31:0] d);
        host_rd = 1; host_addr = a;
        @(negedge clk); host_rd = 0; d = host_rdata;
    endtask

    task automatic take();
        ctl_post_take = 1; @(negedge clk); ctl_post_take = 0;
    endtask

    task automatic cpl(input logic [31:0] w, input logic use_c, input logic [31:0] c);
        ctl_cpl_push = 1; ctl_cpl_word = w; ctl_cpl_use_ctx = use_c; ctl_cpl_ctx = c;
        @(negedge clk); ctl_cpl_push = 0;
    endtask

    function automatic logic [31:0] host_form(input logic [31:0] bus_addr);
        return 32'h8000_0000 | (bus_addr >> 5);
    endfunction

    function automatic logic [31:0] pop_or_empty(inout logic [31:0] q[$]);
        if (q.size() == 0) return EMPTY;
        return q.pop_front();
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, v, w, c;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 host_irq", 32'(host_irq), 0);
        chk("R1 ctl_irq", 32'(ctl_irq), 0);
        chk("R1 post_valid", 32'(ctl_post_valid), 0);
        hrd(8'h30, d); chk("R1 ostat", d, 0);
        hrd(8'h18, d); chk("R1 omsg0", d, 0);
        hrd(8'h44, d); chk("R5 empty cpl read", d, EMPTY);

        // R2 free list order and empty read
        for (int i = 0; i < NFREE; i++) begin
            hrd(8'h40, d); chk("R1 R2 free entry", d, BASE + STEP * i);
        end
        hrd(8'h40, d); chk("R2 empty free read", d, EMPTY);

        // R6 return path
        hwr(8'h44, 32'h8000_1234);
        hrd(8'h40, d); chk("R6 tagged return ignored", d, EMPTY);
        hwr(8'h44, BASE + STEP);
        hrd(8'h40, d); chk("R6 offset returned", d, BASE + STEP);

        // R3 / R7 post FIFO fill past depth
        for (int i = 0; i < DEPTH + 1; i++) begin
            v = (i == 1) ? host_form(32'h0012_3460) : 32'h0000_3000 + 32'(i) * 32'h20;
            hwr(8'h40, v);
            if (i < DEPTH) pq.push_back(v);
        end
        hrd(8'h24, d); chk("R12 istat post not empty", d, 32'h8);
        chk("R12 ctl_irq post", 32'(ctl_irq), 1);
        hrd(8'h30, d); chk("R7 overflow flag", d, 32'h10);
        chk("R11 irq on overflow", 32'(host_irq), 1);
        hwr(8'h30, 32'h10);
        hrd(8'h30, d); chk("R7 overflow cleared", d, 0);
        while (pq.size() > 0) begin
            chk("R3 post valid", 32'(ctl_post_valid), 1);
            chk("R3 post word", ctl_post_word, pq.pop_front());
            take();
        end
        chk("R3 post drained", 32'(ctl_post_valid), 0);
        take();
        chk("R3 take on empty", 32'(ctl_post_valid), 0);

        // R4 / R5 / R10 completions
        cpl(32'h0000_3100, 0, 32'hCAFE_0001);
        cpl(32'h8000_4444, 1, 32'hCAFE_0002);
        hrd(8'h30, d); chk("R10 queue not empty", d, 32'h8);
        hwr(8'h30, 32'hFFFF_FFFF);
        hrd(8'h30, d); chk("R10 level not cleared", d, 32'h8);
        hrd(8'h44, d); chk("R4 word queued", d, 32'h0000_3100);
        hrd(8'h44, d); chk("R4 context queued", d, 32'hCAFE_0002);
        hrd(8'h44, d); chk("R5 empty after drain", d, EMPTY);
        chk("R10 irq idle", 32'(host_irq), 0);

        // R8 inbound messages
        hwr(8'h10, 32'hDEAD_0001);
        chk("R8 imsg0", ctl_imsg0, 32'hDEAD_0001);
        chk("R8 ctl_irq", 32'(ctl_irq), 1);
        hrd(8'h24, d); chk("R8 istat", d, 32'h1);
        hwr(8'h14, 32'h0BAD_F00D);
        chk("R8 imsg1", ctl_imsg1, 32'h0BAD_F00D);
        ctl_imsg_ack = 2'b11; @(negedge clk); ctl_imsg_ack = 0;
        chk("R8 ack clears", 32'(ctl_irq), 0);

        // R9 / R11 outbound messages and mask
        ctl_omsg_wr = 2'b01; ctl_omsg_data = 32'hDEAD_0001; @(negedge clk); ctl_omsg_wr = 0;
        hrd(8'h18, d); chk("R9 omsg0 echo", d, 32'hDEAD_0001);
        hrd(8'h30, d); chk("R9 ostat msg0", d, 32'h1);
        chk("R11 irq msg", 32'(host_irq), 1);
        hwr(8'h34, 32'h1);
        chk("R11 masked", 32'(host_irq), 0);
        hrd(8'h34, d); chk("R11 mask readback", d, 32'h1);
        hwr(8'h34, 32'h0);
        ctl_omsg_wr = 2'b10; ctl_omsg_data = 32'h5555_AAAA; @(negedge clk); ctl_omsg_wr = 0;
        hrd(8'h1C, d); chk("R9 omsg1", d, 32'h5555_AAAA);
        hwr(8'h30, 32'h3);
        hrd(8'h30, d); chk("R9 w1c", d, 0);

        // R12 doorbell
        hwr(8'h20, 32'h5);
        hwr(8'h20, 32'h30);
        chk("R12 doorbell or", ctl_doorbell, 32'h35);
        hrd(8'h24, d); chk("R12 istat db", d, 32'h4);
        chk("R12 ctl_irq db", 32'(ctl_irq), 1);
        hwr(8'h28, 32'h4);
        chk("R12 inbound mask", 32'(ctl_irq), 0);
        ctl_db_clr = 32'h35; @(negedge clk); ctl_db_clr = 0;
        chk("R12 doorbell clear", ctl_doorbell, 0);
        hwr(8'h28, 32'h0);

        // random mix of queue traffic against the model
        ovf = 0;
        for (int it = 0; it < 400; it++) begin
            case ($urandom % 6)
                0: begin hrd(8'h40, d); chk("R2 random free pop", d, pop_or_empty(fq)); end
                1: begin
                    v = ($urandom % 2) ? host_form($urandom & 32'hFFFF_FFE0) : ($urandom & 32'h0000_FFE0);
                    if (pq.size() < DEPTH) pq.push_back(v); else ovf = 1;
                    hwr(8'h40, v);
                end
                2: begin
                    chk("R3 random valid", 32'(ctl_post_valid), 32'(pq.size() > 0));
                    if (pq.size() > 0) chk("R3 random word", ctl_post_word, pq.pop_front());
                    take();
                end
                3: begin
                    w = $urandom; c = $urandom; v = $urandom % 2;
                    if (cq.size() < DEPTH) cq.push_back(v[0] ? c : w); else ovf = 1;
                    cpl(w, v[0], c);
                end
                4: begin hrd(8'h44, d); chk("R5 random cpl pop", d, pop_or_empty(cq)); end
                default: begin
                    v = ($urandom % 3 == 0) ? 32'h8000_0000 | $urandom : ($urandom & 32'h0000_FFE0);
                    if (!v[31]) begin
                        if (fq.size() < DEPTH) fq.push_back(v); else ovf = 1;
                    end
                    hwr(8'h44, v);
                end
            endcase
            chk("R11 random host_irq", 32'(host_irq), 32'(ovf || cq.size() > 0));
            chk("R12 random ctl_irq", 32'(ctl_irq), 32'(pq.size() > 0));
            if (it % 25 == 24) begin
                hrd(8'h30, d);
                chk("R7 R10 random ostat", d, (ovf ? 32'h10 : 0) | (cq.size() > 0 ? 32'h8 : 0));
                hwr(8'h30, 32'h10); ovf = 0;
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule